// File: doc/BRIEF.md
# Bridge Brake and Coast Mode Latch

This block chooses how a three-phase MOSFET bridge behaves: normal run under commutation control, dynamic brake, or coast. Dynamic brake turns every low-side switch on and every high-side switch off, which shorts the motor back-EMF. Coast turns every gate off. The block drives two override outputs, `allLowOn` and `allGatesOff`, which the gate-drive logic must give priority over the commutation pattern. It also drives a registered mode code that names the state.

In normal operation the brake request input selects run or brake directly. A power-loss event is either an undervoltage flag or a rising edge on the external reset input. On that event the block stores the brake-select bit, and the stored bit then decides between brake and coast. Neither the live brake request nor later changes of the select bit affect the outcome. The stored state holds until reset is low and undervoltage has cleared.

The same block keeps a stall-fault flag. Only a reset toggle or a power-up reset clears this flag.

Top module: `brake_coast_latch`

## Requirements
- R1: After `rstN` is released, `modeCode` is 2'b00 (run), `allLowOn` and `allGatesOff` are 0, and `stallFault` is 0.
- R2: With no stored event, `modeCode` follows `brakeReq` one clock edge later: 0 gives run (2'b00) and 1 gives brake (2'b01). The value of `brakeSel` has no effect.
- R3: Mode code 2'b01 (brake) comes with `allLowOn`=1 and `allGatesOff`=0. Mode code 2'b10 (coast) comes with `allGatesOff`=1 and `allLowOn`=0. Run comes with both at 0. The two overrides are never 1 together, and code 2'b11 never appears.
- R4: `uvFlag` high at a clock edge is a trigger event, provided no event is already stored. At that edge `brakeSel` is stored. On the following edge the outputs switch to brake if the stored bit is 1 and to coast if it is 0.
- R5: A rising edge of `resetIn` (sampled 0, then 1) is a trigger event with the same capture and the same two-edge timing as R4.
- R6: While an event is stored, `brakeReq` and later changes of `brakeSel` do not change the mode. A held-high `resetIn` does not capture again.
- R7: The stored event is released at the first edge at which both `resetIn` and `uvFlag` are low. From the next edge the mode follows R2 again. If either input is still high, the stored mode is kept.
- R8: `stallDetect` high at an edge sets `stallFault`, which is visible after that edge. Only a `resetIn` rising edge or `rstN` clears it, and undervoltage does not. When a set and a clear fall on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset, synchronous |
| brakeReq | input | 1 | Brake request used before a trigger event |
| brakeSel | input | 1 | Post-event choice: 1 brake, 0 coast |
| resetIn | input | 1 | External reset line; its rising edge is a trigger event and clears faults |
| uvFlag | input | 1 | Supply undervoltage indication |
| stallDetect | input | 1 | Stall detector pulse |
| modeCode | output | 2 | 00 run, 01 brake, 10 coast |
| allLowOn | output | 1 | Override: all low-side gates on, all high-side gates off |
| allGatesOff | output | 1 | Override: all gates off |
| stallFault | output | 1 | Stored stall fault |

## Verification
The checker watches three things on every cycle:
- the two overrides are never active together, and no illegal mode code appears;
- every `resetIn` rising edge or undervoltage sample leads, two edges later, to a non-run mode;
- a `resetIn` rising edge always leaves the stall flag clear.

Only the bench scenarios can show the remaining behaviour. These cover which of brake or coast follows from the captured select bit, and that the select bit is ignored once an event is stored. They also cover release only when both trigger sources are low, and that the stall flag survives an undervoltage event.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN   = 2'b00,
    MODE_BRAKE = 2'b01,
    MODE_COAST = 2'b10
  } bridgeMode_t;

  typedef struct packed {
    logic capture;     // store brakeSel this edge
    logic active;      // an event is currently stored
    logic faultClear;  // reset toggle seen
  } ctrlStrobes_t;
endpackage

// File: rtl/bcl_ctrl.sv
module bcl_ctrl
  import bcl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         resetIn,
  input  logic         uvFlag,
  output ctrlStrobes_t strobes
);
  logic resetPrevQ;
  logic latchedQ;
  logic resetRise;
  logic trigger;
  logic releaseOk;

  assign resetRise = resetIn & ~resetPrevQ;
  assign trigger   = (uvFlag | resetRise) & ~latchedQ;
  assign releaseOk = latchedQ & ~resetIn & ~uvFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetPrevQ <= 1'b0;
      latchedQ   <= 1'b0;
    end else begin
      resetPrevQ <= resetIn;
      if (trigger)        latchedQ <= 1'b1;
      else if (releaseOk) latchedQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.capture    = trigger;
    strobes.active     = latchedQ;
    strobes.faultClear = resetRise;
  end
endmodule

// File: rtl/bcl_datapath.sv
module bcl_datapath
  import bcl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              brakeReq,
  input  logic              brakeSel,
  input  logic              stallDetect,
  output logic [MODE_W-1:0] modeCode,
  output logic              allLowOn,
  output logic              allGatesOff,
  output logic              stallFault
);
  logic        selQ;
  logic        faultQ;
  bridgeMode_t modeQ;
  bridgeMode_t modeNext;

  always_comb begin
    if (strobes.active) modeNext = selQ ? MODE_BRAKE : MODE_COAST;
    else                modeNext = brakeReq ? MODE_BRAKE : MODE_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ        <= 1'b0;
      faultQ      <= 1'b0;
      modeQ       <= MODE_RUN;
      allLowOn    <= 1'b0;
      allGatesOff <= 1'b0;
    end else begin
      if (strobes.capture) selQ <= brakeSel;
      if (strobes.faultClear) faultQ <= 1'b0;
      else if (stallDetect)   faultQ <= 1'b1;
      modeQ       <= modeNext;
      allLowOn    <= (modeNext == MODE_BRAKE);
      allGatesOff <= (modeNext == MODE_COAST);
    end
  end

  assign modeCode   = modeQ;
  assign stallFault = faultQ;
endmodule

// File: rtl/brake_coast_latch.sv
module brake_coast_latch
  import bcl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              brakeReq,
  input  logic              brakeSel,
  input  logic              resetIn,
  input  logic              uvFlag,
  input  logic              stallDetect,
  output logic [MODE_W-1:0] modeCode,
  output logic              allLowOn,
  output logic              allGatesOff,
  output logic              stallFault
);
  ctrlStrobes_t strobes;

  bcl_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .resetIn (resetIn),
    .uvFlag  (uvFlag),
    .strobes (strobes)
  );

  bcl_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .brakeReq    (brakeReq),
    .brakeSel    (brakeSel),
    .stallDetect (stallDetect),
    .modeCode    (modeCode),
    .allLowOn    (allLowOn),
    .allGatesOff (allGatesOff),
    .stallFault  (stallFault)
  );
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker
  import bcl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              resetIn,
  input logic              uvFlag,
  input logic [MODE_W-1:0] modeCode,
  input logic              allLowOn,
  input logic              allGatesOff,
  input logic              stallFault
);
  assert_override_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(allLowOn && allGatesOff));

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeCode != 2'b11);

  assert_uv_stops_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> ##1 (modeCode != MODE_RUN));

  assert_reset_edge_stops_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetIn) |=> ##1 (modeCode != MODE_RUN));

  assert_reset_edge_clears_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetIn) |=> !stallFault);
endmodule

bind brake_coast_latch bcl_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .resetIn     (resetIn),
  .uvFlag      (uvFlag),
  .modeCode    (modeCode),
  .allLowOn    (allLowOn),
  .allGatesOff (allGatesOff),
  .stallFault  (stallFault)
);

// File: tb/brake_coast_latch_tb_top.sv
module brake_coast_latch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic brakeReq = 1'b0, brakeSel = 1'b0, resetIn = 1'b0, uvFlag = 1'b0, stallDetect = 1'b0;
  logic [1:0] modeCode;
  logic allLowOn, allGatesOff, stallFault;

  always #10 clk = ~clk;

  brake_coast_latch dut_i (
    .clk(clk), .rstN(rstN), .brakeReq(brakeReq), .brakeSel(brakeSel),
    .resetIn(resetIn), .uvFlag(uvFlag), .stallDetect(stallDetect),
    .modeCode(modeCode), .allLowOn(allLowOn), .allGatesOff(allGatesOff),
    .stallFault(stallFault)
  );

  typedef struct {
    bit         isFault;
    logic [1:0] expVal;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      applied++;
      if (it.isFault) begin
        if (stallFault !== it.expVal[0]) begin
          miscompares++;
          $display("FAIL %s stallFault actual=%b expected=%b", it.tag, stallFault, it.expVal[0]);
        end
      end else begin
        logic expLow, expOff;
        expLow = (it.expVal == 2'b01);
        expOff = (it.expVal == 2'b10);
        if (modeCode !== it.expVal || allLowOn !== expLow || allGatesOff !== expOff) begin
          miscompares++;
          $display("FAIL %s mode/lo/off actual=%b/%b/%b expected=%b/%b/%b",
                   it.tag, modeCode, allLowOn, allGatesOff, it.expVal, expLow, expOff);
        end
      end
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectMode(input logic [1:0] m, input string tag);
    expItem_t it;
    it.isFault = 1'b0; it.expVal = m; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expectFault(input logic f, input string tag);
    expItem_t it;
    it.isFault = 1'b1; it.expVal = {1'b0, f}; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);
    expectMode(2'b00, "R1 reset mode");
    expectFault(1'b0, "R1 reset fault");

    // R2 / R3: pre-trigger follows brakeReq, brakeSel ignored
    brakeReq = 1'b1; brakeSel = 1'b0; waitEdges(2); expectMode(2'b01, "R2 brake sel0 R3");
    brakeReq = 1'b0; brakeSel = 1'b1; waitEdges(2); expectMode(2'b00, "R2 run sel1");
    brakeReq = 1'b1;                  waitEdges(1); expectMode(2'b01, "R2 brake one edge");

    // R4: undervoltage captures sel=0 -> coast
    brakeSel = 1'b0; uvFlag = 1'b1;   waitEdges(2); expectMode(2'b10, "R4 uv coast R3");
    brakeSel = 1'b1;                  waitEdges(2); expectMode(2'b10, "R6 sel change ignored");
    brakeReq = 1'b0;                  waitEdges(2); expectMode(2'b10, "R6 brakeReq ignored");

    // R7: release when both low
    uvFlag = 1'b0;                    waitEdges(2); expectMode(2'b00, "R7 release to run");

    // R5: reset rising edge captures sel=1 -> brake
    brakeSel = 1'b1; resetIn = 1'b1;  waitEdges(2); expectMode(2'b01, "R5 reset edge brake");
    brakeSel = 1'b0;                  waitEdges(3); expectMode(2'b01, "R6 held reset no recapture");
    resetIn = 1'b0;                   waitEdges(2); expectMode(2'b00, "R7 reset low release");

    // R5 coast, then R7 with uv still high
    resetIn = 1'b1; brakeSel = 1'b0;  waitEdges(2); expectMode(2'b10, "R5 reset edge coast");
    resetIn = 1'b0; uvFlag = 1'b1; brakeSel = 1'b1;
                                      waitEdges(3); expectMode(2'b10, "R7 uv high holds");
    brakeReq = 1'b1; uvFlag = 1'b0;   waitEdges(2); expectMode(2'b01, "R7 release follows brakeReq");

    // R8: stall fault
    stallDetect = 1'b1;               waitEdges(1); expectFault(1'b1, "R8 fault set");
    stallDetect = 1'b0;               waitEdges(2); expectFault(1'b1, "R8 fault held");
    uvFlag = 1'b1;                    waitEdges(2); expectFault(1'b1, "R8 uv keeps fault");
    uvFlag = 1'b0;                    waitEdges(2);
    resetIn = 1'b1;                   waitEdges(1); expectFault(1'b0, "R8 reset edge clears");
    resetIn = 1'b0; stallDetect = 1'b1; waitEdges(1); expectFault(1'b1, "R8 set again");
    stallDetect = 1'b0;               waitEdges(1);
    resetIn = 1'b1; stallDetect = 1'b1; waitEdges(1); expectFault(1'b0, "R8 clear wins");
                                      waitEdges(1); expectFault(1'b1, "R8 set after clear");
    stallDetect = 1'b0; resetIn = 1'b0; waitEdges(2);

    // R1: power-up reset mid-run clears fault and mode
    stallDetect = 1'b1; brakeReq = 1'b1; waitEdges(2);
    stallDetect = 1'b0; rstN = 1'b0;   waitEdges(2);
    rstN = 1'b1; brakeReq = 1'b0;      @(negedge clk);
    expectMode(2'b00, "R1 re-reset mode");
    expectFault(1'b0, "R1 re-reset fault");

    waitEdges(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule